// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked memory that behaves like a pipelined synchronous burst SRAM. Each word holds two byte lanes of parameterised width. The block samples every control input on the rising clock edge. It decodes three chip selects, two address strobes, a burst-advance input and a set of write enables. From these it decides, in each cycle, to do one of four things: drop the selection, load a new external address, step a 2-bit burst offset, or access the current address again.

The host-side strobe always starts a read. The controller-side strobe starts a write or a read, and the byte-write enables choose which. The burst offset stays inside an aligned group of four words. A mode input, sampled when a burst starts, picks the offset order: linear or interleaved. Read data is registered and comes out with a valid flag one clock after the access.

Top module: `sync_burst_sram`

## Requirements
- R1: After synchronous reset, `rd_valid` is 0 and `rd_data` is 0, and no burst is active. Step or repeat cycles issued before any burst start make no access.
- R2: A cycle with `sel_main_n`=1 and `ctl_strobe_n`=0 is a deselect. It writes nothing, gives `rd_valid`=0 in the next cycle and ends any open burst.
- R3: With `sel_main_n`=0 and either strobe low, the cycle is a deselect if `sel_hi`=0 or `sel_lo_n`=1. It writes nothing and gives `rd_valid`=0 in the next cycle.
- R4: With the chip fully selected and `host_strobe_n`=0, a read burst starts at `addr`, whatever the write enables are. No lane is written, and the word at `addr` appears with `rd_valid`=1 one cycle later.
- R5: With the chip fully selected, `host_strobe_n`=1 and `ctl_strobe_n`=0, a burst starts at `addr`. The cycle is a write if the byte-write decode (R9) selects any lane, and a read otherwise.
- R6: With no start and no deselect, `adv_n`=0 steps the 2-bit offset by one, wrapping modulo 4. In linear mode the low two address bits are start+offset (mod 4).
- R7: When `ilv_mode`=1 is sampled at burst start, the low two address bits are start XOR offset. For a start of 1 the order is 1,0,3,2.
- R8: With no start and no deselect, `adv_n`=1 accesses the current address again and leaves the offset unchanged.
- R9: Byte-write decode: `gwr_n`=0 writes both lanes. Otherwise, with `bwr_n`=0, each lane whose `lane_we_n` bit is 0 is written; bit 0 is bits 8:0 and bit 1 is bits 17:9. All other cases are reads.
- R10: The address bits above the low two are taken from `addr` only at burst start and are held through the burst.
- R11: `rd_valid` is 1 exactly one cycle after a read access, and 0 after write cycles, deselects and cycles with no open burst.
- R12: When `sel_main_n`=1 and `ctl_strobe_n`=1, the host strobe is ignored, and `adv_n` still steps or repeats the open burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_main_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Secondary chip select, active low |
| host_strobe_n | input | 1 | Host-side address strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| ilv_mode | input | 1 | 1 selects interleaved burst order |
| addr | input | ADDR_W | External word address |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_valid | output | 1 | Read data valid |

## Verification
The bench builds the block with ADDR_W=8, LANE_W=9 and LANES=2, which gives a 256-word array. Every burst group it uses lies inside one 4-word block. This lets the bench move the address input to unrelated values in mid-burst, so it can show that the upper bits are held. It also makes both wrap orders, lane-masked writes and the deselect paths all visible in a few hundred cycles.

// File: rtl/sbs_pkg.sv
// Shared types for the synchronous burst SRAM core.
// Assumes: one command is decoded per clock; the encoding is internal only.
package sbs_pkg;
    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,   // drop selection, end burst
        OP_LOAD  = 2'd1,   // start burst at external address
        OP_STEP  = 2'd2,   // advance burst offset
        OP_HOLD  = 2'd3    // access current address again
    } op_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
// Command decoder: turns the sampled selects, strobes and advance input into
// one operation per cycle, and turns the write enables into a lane mask.
// Assumes: inputs are stable around the rising edge; purely combinational.
module sbs_cmd_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_main_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             host_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_we_n,
    output op_e              op,
    output logic [LANES-1:0] lane_wr
);
    logic sec_ok;
    logic any_strobe;
    logic host_start;
    logic [LANES-1:0] lanes_req;

    // Qualification terms shared by the decode below.
    always_comb begin
        sec_ok     = sel_hi && !sel_lo_n;
        any_strobe = !host_strobe_n || !ctl_strobe_n;
        host_start = !sel_main_n && sec_ok && !host_strobe_n;
    end

    // Operation decode, in priority order.
    always_comb begin
        if (sel_main_n && !ctl_strobe_n)
            op = OP_DESEL;
        else if (!sel_main_n && any_strobe && !sec_ok)
            op = OP_DESEL;
        else if (!sel_main_n && any_strobe)
            op = OP_LOAD;
        else if (!adv_n)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end

    // Byte-lane write mask; a host-strobe start never writes.
    always_comb begin
        if (!gwr_n)
            lanes_req = '1;
        else if (!bwr_n)
            lanes_req = ~lane_we_n;
        else
            lanes_req = '0;
        lane_wr = host_start ? '0 : lanes_req;
    end
endmodule

// File: rtl/sbs_burst_ctr.sv
// Burst address generator: latches the upper address and start offset on a
// load, steps a 2-bit offset, and forms the address accessed this cycle.
// Assumes: bursts wrap inside an aligned group of 4 words.
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ilv_mode,
    output logic              acc_en,
    output logic [ADDR_W-1:0] acc_addr
);
    localparam int CNT_W = 2;
    localparam int HI_W  = ADDR_W - CNT_W;

    logic             act_q,  act_d;
    logic [HI_W-1:0]  hi_q,   hi_d;
    logic [CNT_W-1:0] base_q, base_d;
    logic [CNT_W-1:0] cnt_q,  cnt_d;
    logic             ilv_q,  ilv_d;
    logic [CNT_W-1:0] lo;

    // Next-state selection for the burst registers.
    always_comb begin
        act_d  = act_q;
        hi_d   = hi_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        ilv_d  = ilv_q;
        unique case (op)
            OP_LOAD: begin
                act_d  = 1'b1;
                hi_d   = addr[ADDR_W-1:CNT_W];
                base_d = addr[CNT_W-1:0];
                cnt_d  = '0;
                ilv_d  = ilv_mode;
            end
            OP_DESEL: act_d = 1'b0;
            OP_STEP:  if (act_q) cnt_d = cnt_q + CNT_W'(1);
            default:  ;
        endcase
    end

    // Access address for this cycle, in linear or interleaved order.
    always_comb begin
        lo       = ilv_d ? (base_d ^ cnt_d) : (base_d + cnt_d);
        acc_addr = {hi_d, lo};
        acc_en   = act_d;
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else begin
            act_q  <= act_d;
            hi_q   <= hi_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
            ilv_q  <= ilv_d;
        end
    end

    p_step_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && act_q) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    p_hold_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(cnt_q) && $stable(base_q));
    p_hi_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP || op == OP_HOLD) |=> $stable(hi_q));
endmodule

// File: rtl/sbs_lane_array.sv
// Storage with one array per byte lane and registered read data.
// Assumes: a cycle with any lane selected is a write; otherwise an enabled
// access is a read whose data and valid flag appear after the next edge.
module sbs_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic is_read;
    assign is_read = acc_en && (lane_wr == '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Lane write port.
        always_ff @(posedge clk) begin
            if (acc_en && lane_wr[g])
                mem[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Lane read register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_q <= '0;
            else if (is_read)
                rd_q <= mem[acc_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_q;
    end

    // Read-valid flag, one cycle behind the access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= is_read;
    end

    p_write_no_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr != '0) |=> !rd_valid);
    p_idle_no_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !rd_valid);
endmodule

// File: rtl/sync_burst_sram.sv
// Top of the synchronous burst SRAM core: command decode, burst address
// generation and lane storage. All inputs are sampled on the rising edge;
// reset is synchronous and active low.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_main_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    host_strobe_n,
    input  logic                    ctl_strobe_n,
    input  logic                    adv_n,
    input  logic                    gwr_n,
    input  logic                    bwr_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    ilv_mode,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);
    op_e               op;
    logic [LANES-1:0]  lane_wr;
    logic              acc_en;
    logic [ADDR_W-1:0] acc_addr;

    sbs_cmd_decode #(.LANES(LANES)) u_dec (
        .sel_main_n   (sel_main_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .host_strobe_n(host_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .adv_n        (adv_n),
        .gwr_n        (gwr_n),
        .bwr_n        (bwr_n),
        .lane_we_n    (lane_we_n),
        .op           (op),
        .lane_wr      (lane_wr)
    );

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .addr    (addr),
        .ilv_mode(ilv_mode),
        .acc_en  (acc_en),
        .acc_addr(acc_addr)
    );

    sbs_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (acc_en),
        .acc_addr(acc_addr),
        .lane_wr (lane_wr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    p_main_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_main_n && !ctl_strobe_n) |=> !rd_valid);
    p_sec_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_main_n && (!host_strobe_n || !ctl_strobe_n) && (!sel_hi || sel_lo_n))
        |=> !rd_valid);
    p_host_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_main_n && sel_hi && !sel_lo_n && !host_strobe_n) |=> rd_valid);
endmodule

// File: tb/sim_sync_burst_sram.sv
// Scoreboard bench: the driver pushes one expected item per cycle, the
// monitor pops and compares after each rising edge.
module sim_sync_burst_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int LW = 9;
    localparam int LN = 2;
    localparam int DW = LW * LN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s1n = 1'b1, s2 = 1'b1, s3n = 1'b0, hsn = 1'b1, csn = 1'b1, avn = 1'b1;
    logic gwn = 1'b1, bwn = 1'b1, ilv = 1'b0;
    logic [LN-1:0] lwn = '1;
    logic [AW-1:0] a = '0;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] rd;
    logic rv;

    typedef struct { logic v; logic [DW-1:0] d; string tag; } exp_t;
    exp_t q[$];
    logic [DW-1:0] ref_mem [1 << AW];
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(LN)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_main_n(s1n), .sel_hi(s2), .sel_lo_n(s3n),
        .host_strobe_n(hsn), .ctl_strobe_n(csn), .adv_n(avn), .gwr_n(gwn),
        .bwr_n(bwn), .lane_we_n(lwn), .ilv_mode(ilv), .addr(a), .wr_data(wd),
        .rd_data(rd), .rd_valid(rv)
    );

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 18'h1357 + 18'h0A5);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // kind: 0 no access, 1 read at ea, 2 write at ea
    task automatic cyc(input logic i_s1n, i_s2, i_s3n, i_hsn, i_csn, i_avn, i_gwn, i_bwn,
                       input logic [LN-1:0] i_lwn, input logic i_ilv, input logic [AW-1:0] i_a,
                       input logic [DW-1:0] i_d, input int kind, input int ea, input string tag);
        exp_t e;
        logic [LN-1:0] m;
        @(negedge clk);
        s1n = i_s1n; s2 = i_s2; s3n = i_s3n; hsn = i_hsn; csn = i_csn; avn = i_avn;
        gwn = i_gwn; bwn = i_bwn; lwn = i_lwn; ilv = i_ilv; a = i_a; wd = i_d;
        e.tag = tag; e.v = 1'b0; e.d = '0;
        if (kind == 1) begin
            e.v = 1'b1;
            e.d = ref_mem[ea];
        end else if (kind == 2) begin
            m = !i_gwn ? '1 : (!i_bwn ? ~i_lwn : '0);
            for (int g = 0; g < LN; g++)
                if (m[g]) ref_mem[ea][g*LW +: LW] = i_d[g*LW +: LW];
        end
        q.push_back(e);
    endtask

    task automatic host_go(input logic [AW-1:0] ad, input logic il, input logic g, input string tag);
        cyc(0, 1, 0, 0, 1, 1, g, 1, '1, il, ad, '1, 1, int'(ad), tag);
    endtask

    task automatic ctl_go(input logic [AW-1:0] ad, input logic g, input logic b,
                          input logic [LN-1:0] l, input logic [DW-1:0] d, input int kind, input string tag);
        cyc(0, 1, 0, 1, 0, 1, g, b, l, 0, ad, d, kind, int'(ad), tag);
    endtask

    task automatic nxt(input logic av, input logic g, input logic [AW-1:0] ad,
                       input logic [DW-1:0] d, input int kind, input int ea, input string tag);
        cyc(0, 1, 0, 1, 1, av, g, 1, '1, 0, ad, d, kind, ea, tag);
    endtask

    // Monitor: compare one expected item per cycle after the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " valid"}, DW'(rv), DW'(e.v));
            if (e.v) check({e.tag, " data"}, rd, e.d);
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", DW'(rv), '0);
        check("R1 reset data", rd, '0);
        rst_n = 1'b1;
        nxt(0, 1, 8'h40, '0, 0, 0, "R1 step without burst");
        nxt(1, 0, 8'h40, 18'h3FFFF, 0, 0, "R1 repeat without burst");

        // R5 R6 R9: controller-strobe write burst, linear, both lanes
        ctl_go(8'h40, 0, 1, '1, pat(0), 2, "R5 write start");
        nxt(0, 0, 8'h00, pat(1), 2, 'h41, "R6 write step");
        nxt(0, 0, 8'h00, pat(2), 2, 'h42, "R6 write step");
        nxt(0, 0, 8'h00, pat(3), 2, 'h43, "R6 write step");
        ctl_go(8'h46, 0, 1, '1, pat(6), 2, "R5 write start 46");
        nxt(0, 0, 8'h00, pat(7), 2, 'h47, "R6 step 47");
        nxt(0, 0, 8'h00, pat(4), 2, 'h44, "R6 wrap to 44");
        nxt(0, 0, 8'h00, pat(5), 2, 'h45, "R6 step 45");

        // R4 R10 R6: host start ignores write enables; upper bits held
        host_go(8'h40, 0, 0, "R4 host read ignores gwr");
        nxt(0, 1, 8'hFF, '0, 1, 'h41, "R10 upper bits held");
        nxt(0, 1, 8'h9C, '0, 1, 'h42, "R10 step 42");
        nxt(0, 1, 8'h00, '0, 1, 'h43, "R6 step 43");
        nxt(0, 1, 8'h00, '0, 1, 'h40, "R6 wrap to 40");

        // R7: interleaved from 45
        host_go(8'h45, 1, 1, "R7 start 45");
        nxt(0, 1, 8'h00, '0, 1, 'h44, "R7 order 44");
        nxt(0, 1, 8'h00, '0, 1, 'h47, "R7 order 47");
        nxt(0, 1, 8'h00, '0, 1, 'h46, "R7 order 46");

        // R8: suspend
        host_go(8'h42, 0, 1, "R8 start 42");
        nxt(1, 1, 8'h47, '0, 1, 'h42, "R8 repeat 42");
        nxt(1, 1, 8'h47, '0, 1, 'h42, "R8 repeat again");
        nxt(0, 1, 8'h47, '0, 1, 'h43, "R8 step after repeat");

        // R9 R5: byte lanes and read starts via controller strobe
        ctl_go(8'h41, 1, 0, 2'b10, 18'h3FFFF, 2, "R9 lane0 write");
        ctl_go(8'h42, 1, 0, 2'b11, 18'h3FFFF, 1, "R9 bwr with no lane reads");
        ctl_go(8'h43, 1, 1, 2'b00, 18'h3FFFF, 1, "R9 bwr high reads");
        ctl_go(8'h44, 1, 0, 2'b01, 18'h00000, 2, "R9 lane1 write");
        host_go(8'h41, 0, 1, "R9 lane0 only changed");
        nxt(0, 1, 8'h00, '0, 1, 'h42, "R9 42 unchanged");
        host_go(8'h44, 0, 1, "R9 lane1 only changed");

        // R2 R11: primary deselect
        cyc(1, 1, 0, 1, 0, 0, 0, 1, '1, 0, 8'h40, 18'h00000, 0, 0, "R2 deselect");
        nxt(0, 1, 8'h40, '0, 0, 0, "R11 step after deselect");
        nxt(0, 0, 8'h40, 18'h00000, 0, 0, "R2 no write after deselect");
        host_go(8'h40, 0, 1, "R2 data kept");

        // R3: secondary selects
        cyc(0, 0, 0, 0, 1, 1, 0, 1, '1, 0, 8'h40, 18'h00000, 0, 0, "R3 sel_hi low");
        cyc(0, 1, 1, 1, 0, 1, 0, 1, '1, 0, 8'h40, 18'h00000, 0, 0, "R3 sel_lo_n high");
        nxt(0, 0, 8'h40, 18'h00000, 0, 0, "R3 no burst left");
        host_go(8'h40, 0, 1, "R3 data kept");

        // R12: primary high, host strobe ignored, burst steps
        host_go(8'h44, 0, 1, "R12 start 44");
        cyc(1, 1, 0, 0, 1, 0, 1, 1, '1, 0, 8'h80, '0, 1, 'h45, "R12 step with host low");

        repeat (3) @(negedge clk);
        check("R11 queue drained", DW'(q.size()), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule